// File: doc/BRIEF.md
# Matrix-Based Issue Wakeup and Select

This block is the scheduling core of an out-of-order issue window. It holds WS instruction slots. Each slot has a valid flag and a ready flag for each of its two source operands. It also owns one row in each of two WS-by-WS bit matrices, one matrix for the left operand and one for the right. A set bit at row c, column p records that the operand of the instruction in slot c comes from the instruction in slot p. Operands are not found by broadcasting result tags and comparing them against every slot. When producers are granted, the block ORs their matrix columns, and the resulting vector sets the consumers' ready flags. No comparator is involved.

Every cycle, a fixed-priority selector grants up to IW requesting slots. A slot requests when it is valid and both of its ready flags are set. The wakeup caused by this cycle's grants lands at the same clock edge. A dependent instruction with one-cycle latency can therefore be granted in the very next cycle. Up to IW dispatch lanes per cycle write a slot's matrix rows and its initial ready flags. The upstream logic supplies the producer slot numbers and chooses free slots. A flush input empties the window at once.

Each slot has a two-state life held in an enumerated state. SLOT_EMPTY moves to SLOT_BUSY on a dispatch to that slot. SLOT_BUSY moves to SLOT_EMPTY when the slot is granted or when flush is high. SLOT_BUSY stays in SLOT_BUSY when it is re-dispatched in its grant cycle.

Top module: `dm_wakeup_sched`

## Requirements
- R1: While reset is asserted and after its release, with no dispatch, slot_req and issue_gnt are all zero.
- R2: A slot dispatched with both initial ready inputs at 1 shows its slot_req bit from the next cycle. A slot dispatched with either ready input at 0 and no producer granted does not request.
- R3: slot_req bit c is 1 exactly when slot c is valid and both of its ready flags are 1. A valid slot waiting on a producer that never issues never requests.
- R4: Slots are prioritised by index, with slot 0 highest. Each cycle issue_gnt grants the lowest-indexed requesting slots, at most IW of them. When IW or fewer slots request, all of them are granted. Bit i of issue_gnt and slot_req refers to slot i.
- R5: A slot granted in a cycle is empty from the next cycle and is not granted again unless it is dispatched anew.
- R6: At the edge that ends a grant cycle, every slot whose left (right) row has a bit set at a granted slot's column gets its left (right) ready flag set. A ready consumer is therefore granted in the cycle right after its producer. Ready flags stay set until the slot is dispatched again.
- R7: Producers granted together in one cycle wake a shared consumer jointly. A consumer whose left and right producers are granted together becomes ready in the next cycle.
- R8: A slot dispatched in the same cycle as the grant of one of its producers has the matching ready flag set by that grant. It does not miss the wakeup.
- R9: Rows left behind in empty slots are not cleared. Ready flags set through them in empty slots never cause a request.
- R10: While flush is high, issue_gnt is zero, dispatch lanes are ignored, and every slot is empty from the next cycle.
- R11: Dispatch lane k carries its slot number in disp_slot[k*IDXW +: IDXW] and its rows in disp_lsrc/disp_rsrc[k*WS +: WS]. Row bit p set means the producer is slot p, and each row has at most one bit set. When two lanes name the same slot, the higher lane's fields are used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empty every slot; blocks grants and dispatch this cycle |
| disp_vld | input | IW | Per-lane dispatch strobe |
| disp_slot | input | IW*IDXW | Per-lane target slot number |
| disp_lsrc | input | IW*WS | Per-lane one-hot left producer row (zero if none) |
| disp_rsrc | input | IW*WS | Per-lane one-hot right producer row (zero if none) |
| disp_lrdy | input | IW | Per-lane initial left ready flag |
| disp_rrdy | input | IW | Per-lane initial right ready flag |
| slot_req | output | WS | Per-slot request (valid and both operands ready) |
| issue_gnt | output | WS | Per-slot grant for this cycle |

## Verification
Several properties are checked on every cycle: the grant count never exceeds IW, grants stay inside the request set, every request is granted when there are few enough, a wakeup always leaves the ready flag set, a granted slot empties, a flush empties everything, and no grant appears during a flush. Stored rows stay one-hot as well. Other behaviours only show up in the bench's scenarios. These are the back-to-back issue down a dependent chain, joint wakeup of a consumer by two producers granted together, wakeup of a slot dispatched in the producer's grant cycle, stale rows in empty slots staying silent, and the ordering of grants across several cycles. For these, a behavioural model of the window is compared against slot_req and issue_gnt every clock.

// File: rtl/dm_sched_pkg.sv
package dm_sched_pkg;

    // Life of one issue-window slot
    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_BUSY  = 1'b1
    } slot_state_e;

endpackage

// File: rtl/dm_select.sv
// Fixed-priority selector: slot 0 is highest; up to IW grants per cycle,
// decided from a running count of higher-priority requests.
module dm_select #(
    parameter int WS = 16,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [WS-1:0] req,
    output logic [WS-1:0] gnt
);
    localparam int CW = $clog2(WS + 1);

    logic [CW-1:0] ahead [WS+1];

    assign ahead[0] = '0;

    for (genvar i = 0; i < WS; i++) begin : g_pri
        assign gnt[i]       = en && req[i] && (ahead[i] < CW'(IW));
        assign ahead[i + 1] = ahead[i] + CW'(req[i]);
    end

    p_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(gnt) <= IW);

    p_subset_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0);

    p_all_granted_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ($countones(req) <= IW)) |-> (gnt == req));

endmodule

// File: rtl/dm_matrix.sv
// One dependence matrix (left or right operand). Row c holds the one-hot
// producer of slot c. Wakeup for each slot is the OR of its row bits at the
// granted columns; a row being written this cycle is read with its new value.
module dm_matrix #(
    parameter int WS   = 16,
    parameter int IW   = 2,
    parameter int IDXW = $clog2(WS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IW-1:0]    wr_vld,
    input  logic [IW*IDXW-1:0] wr_idx,
    input  logic [IW*WS-1:0] wr_row,
    input  logic [WS-1:0]    gnt,
    output logic [WS-1:0]    wake
);
    logic [WS-1:0] rows     [WS];
    logic [WS-1:0] rows_nxt [WS];

    always_comb begin
        for (int c = 0; c < WS; c++) begin
            rows_nxt[c] = rows[c];
            for (int k = 0; k < IW; k++) begin
                if (wr_vld[k] && (wr_idx[k*IDXW +: IDXW] == IDXW'(c))) begin
                    rows_nxt[c] = wr_row[k*WS +: WS];
                end
            end
            wake[c] = |(rows_nxt[c] & gnt);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < WS; c++) begin
                rows[c] <= '0;
            end
        end else begin
            for (int c = 0; c < WS; c++) begin
                rows[c] <= rows_nxt[c];
            end
        end
    end

    for (genvar c = 0; c < WS; c++) begin : g_chk
        p_row_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(rows[c]));
    end

endmodule

// File: rtl/dm_slots.sv
// Per-slot valid state and operand ready flags; produces the request vector.
module dm_slots
    import dm_sched_pkg::*;
#(
    parameter int WS   = 16,
    parameter int IW   = 2,
    parameter int IDXW = $clog2(WS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic [IW-1:0]      wr_vld,
    input  logic [IW*IDXW-1:0] wr_idx,
    input  logic [IW-1:0]      wr_lrdy,
    input  logic [IW-1:0]      wr_rrdy,
    input  logic [WS-1:0]      gnt,
    input  logic [WS-1:0]      wake_l,
    input  logic [WS-1:0]      wake_r,
    output logic [WS-1:0]      req
);
    slot_state_e   st     [WS];
    slot_state_e   st_nxt [WS];
    logic [WS-1:0] rdy_l, rdy_r;
    logic [WS-1:0] rdy_l_nxt, rdy_r_nxt;
    logic [WS-1:0] hit;
    logic [WS-1:0] init_l, init_r;

    // Dispatch decode: which slots are written and with which initial flags
    always_comb begin
        for (int c = 0; c < WS; c++) begin
            hit[c]    = 1'b0;
            init_l[c] = 1'b0;
            init_r[c] = 1'b0;
            for (int k = 0; k < IW; k++) begin
                if (wr_vld[k] && (wr_idx[k*IDXW +: IDXW] == IDXW'(c))) begin
                    hit[c]    = 1'b1;
                    init_l[c] = wr_lrdy[k];
                    init_r[c] = wr_rrdy[k];
                end
            end
        end
    end

    // Next state of each slot
    always_comb begin
        for (int c = 0; c < WS; c++) begin
            st_nxt[c] = st[c];
            unique case (st[c])
                SLOT_EMPTY: if (hit[c]) st_nxt[c] = SLOT_BUSY;
                SLOT_BUSY:  if (gnt[c] && !hit[c]) st_nxt[c] = SLOT_EMPTY;
            endcase
            if (flush) begin
                st_nxt[c] = SLOT_EMPTY;
            end
            rdy_l_nxt[c] = (hit[c] ? init_l[c] : rdy_l[c]) | wake_l[c];
            rdy_r_nxt[c] = (hit[c] ? init_r[c] : rdy_r[c]) | wake_r[c];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < WS; c++) begin
                st[c] <= SLOT_EMPTY;
            end
            rdy_l <= '0;
            rdy_r <= '0;
        end else begin
            for (int c = 0; c < WS; c++) begin
                st[c] <= st_nxt[c];
            end
            rdy_l <= rdy_l_nxt;
            rdy_r <= rdy_r_nxt;
        end
    end

    // Request outputs
    always_comb begin
        for (int c = 0; c < WS; c++) begin
            req[c] = (st[c] == SLOT_BUSY) && rdy_l[c] && rdy_r[c];
        end
    end

    for (genvar c = 0; c < WS; c++) begin : g_chk
        p_wake_left_r6: assert property (@(posedge clk) disable iff (!rst_n)
            wake_l[c] |=> rdy_l[c]);
        p_wake_right_r6: assert property (@(posedge clk) disable iff (!rst_n)
            wake_r[c] |=> rdy_r[c]);
        p_leave_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (gnt[c] && !hit[c]) |=> (st[c] == SLOT_EMPTY));
        p_flush_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
            flush |=> (st[c] == SLOT_EMPTY));
    end

endmodule

// File: rtl/dm_wakeup_sched.sv
// Issue-window wakeup and select driven by dependence matrices.
module dm_wakeup_sched #(
    parameter int WS = 16,
    parameter int IW = 2,
    localparam int IDXW = $clog2(WS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic [IW-1:0]      disp_vld,
    input  logic [IW*IDXW-1:0] disp_slot,
    input  logic [IW*WS-1:0]   disp_lsrc,
    input  logic [IW*WS-1:0]   disp_rsrc,
    input  logic [IW-1:0]      disp_lrdy,
    input  logic [IW-1:0]      disp_rrdy,
    output logic [WS-1:0]      slot_req,
    output logic [WS-1:0]      issue_gnt
);
    logic [IW-1:0] wr_vld;
    logic [WS-1:0] wake_l, wake_r;

    // A flush blocks this cycle's dispatch lanes
    assign wr_vld = disp_vld & {IW{~flush}};

    dm_select #(.WS(WS), .IW(IW)) u_select (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (~flush),
        .req   (slot_req),
        .gnt   (issue_gnt)
    );

    dm_matrix #(.WS(WS), .IW(IW), .IDXW(IDXW)) u_mat_left (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_vld (wr_vld),
        .wr_idx (disp_slot),
        .wr_row (disp_lsrc),
        .gnt    (issue_gnt),
        .wake   (wake_l)
    );

    dm_matrix #(.WS(WS), .IW(IW), .IDXW(IDXW)) u_mat_right (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_vld (wr_vld),
        .wr_idx (disp_slot),
        .wr_row (disp_rsrc),
        .gnt    (issue_gnt),
        .wake   (wake_r)
    );

    dm_slots #(.WS(WS), .IW(IW), .IDXW(IDXW)) u_slots (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .wr_vld  (wr_vld),
        .wr_idx  (disp_slot),
        .wr_lrdy (disp_lrdy),
        .wr_rrdy (disp_rrdy),
        .gnt     (issue_gnt),
        .wake_l  (wake_l),
        .wake_r  (wake_r),
        .req     (slot_req)
    );

    p_no_grant_in_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (issue_gnt == '0));

endmodule

// File: tb/dm_wakeup_sched_tb.sv
module dm_wakeup_sched_tb_top;
    localparam int WS   = 16;
    localparam int IW   = 2;
    localparam int IDXW = 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic               rst_n;
    logic               flush;
    logic [IW-1:0]      disp_vld;
    logic [IW*IDXW-1:0] disp_slot;
    logic [IW*WS-1:0]   disp_lsrc, disp_rsrc;
    logic [IW-1:0]      disp_lrdy, disp_rrdy;
    logic [WS-1:0]      slot_req, issue_gnt;

    dm_wakeup_sched #(.WS(WS), .IW(IW)) dut_i (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .disp_vld(disp_vld), .disp_slot(disp_slot),
        .disp_lsrc(disp_lsrc), .disp_rsrc(disp_rsrc),
        .disp_lrdy(disp_lrdy), .disp_rrdy(disp_rrdy),
        .slot_req(slot_req), .issue_gnt(issue_gnt)
    );

    int    checks = 0;
    int    errors = 0;
    bit    done   = 1'b0;
    string tag    = "R1";

    // Behavioural model of the window
    bit            m_vld [WS];
    bit            m_rl  [WS];
    bit            m_rr  [WS];
    bit [WS-1:0]   m_lrow [WS];
    bit [WS-1:0]   m_rrow [WS];
    bit [WS-1:0]   exp_req, exp_gnt;

    task automatic check_vec(string what, logic [WS-1:0] act, logic [WS-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic void model_comb();
        int taken = 0;
        exp_req = '0;
        exp_gnt = '0;
        for (int c = 0; c < WS; c++) begin
            exp_req[c] = m_vld[c] && m_rl[c] && m_rr[c];
        end
        for (int c = 0; c < WS; c++) begin
            if (!flush && exp_req[c] && taken < IW) begin
                exp_gnt[c] = 1'b1;
                taken++;
            end
        end
    endfunction

    function automatic void model_edge();
        for (int c = 0; c < WS; c++) begin
            if ((m_lrow[c] & exp_gnt) != '0) m_rl[c] = 1'b1;
            if ((m_rrow[c] & exp_gnt) != '0) m_rr[c] = 1'b1;
            if (exp_gnt[c]) m_vld[c] = 1'b0;
        end
        if (!flush) begin
            for (int k = 0; k < IW; k++) begin
                if (disp_vld[k]) begin
                    int s = int'(disp_slot[k*IDXW +: IDXW]);
                    m_lrow[s] = disp_lsrc[k*WS +: WS];
                    m_rrow[s] = disp_rsrc[k*WS +: WS];
                    m_rl[s]   = disp_lrdy[k] || ((m_lrow[s] & exp_gnt) != '0);
                    m_rr[s]   = disp_rrdy[k] || ((m_rrow[s] & exp_gnt) != '0);
                    m_vld[s]  = 1'b1;
                end
            end
        end else begin
            for (int c = 0; c < WS; c++) m_vld[c] = 1'b0;
        end
    endfunction

    // Compare this cycle, advance one clock, return at the falling edge
    task automatic step();
        #1;
        model_comb();
        check_vec("slot_req", slot_req, exp_req);
        check_vec("issue_gnt", issue_gnt, exp_gnt);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        disp_vld = '0;
        flush    = 1'b0;
    endtask

    // lp/rp = producer slot, or -1 for none
    task automatic disp(int lane, int slot, int lp, int rp, bit lr, bit rr);
        disp_vld[lane]                = 1'b1;
        disp_slot[lane*IDXW +: IDXW]  = IDXW'(slot);
        disp_lsrc[lane*WS +: WS]      = (lp < 0) ? '0 : (WS'(1) << lp);
        disp_rsrc[lane*WS +: WS]      = (rp < 0) ? '0 : (WS'(1) << rp);
        disp_lrdy[lane]               = lr;
        disp_rrdy[lane]               = rr;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL %s watchdog actual=hung expected=finished", tag);
            summary();
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < WS; c++) begin
            m_vld[c] = 0; m_rl[c] = 0; m_rr[c] = 0; m_lrow[c] = '0; m_rrow[c] = '0;
        end
        rst_n = 1'b0; flush = 1'b0; disp_vld = '0; disp_slot = '0;
        disp_lsrc = '0; disp_rsrc = '0; disp_lrdy = '0; disp_rrdy = '0;

        // R1: reset state
        tag = "R1";
        repeat (2) @(negedge clk);
        #1;
        check_vec("slot_req in reset", slot_req, '0);
        check_vec("issue_gnt in reset", issue_gnt, '0);
        rst_n = 1'b1;
        step();

        // R6: chain ld(0) -> sla(1), sla(2) -> add(3), one cycle apart
        tag = "R6";
        disp(0, 0, -1, -1, 1, 1);
        disp(1, 1, 0, -1, 0, 1);
        step();
        // R8: slot 2 dispatched while its producer (slot 0) is granted
        tag = "R8";
        disp(0, 2, 0, -1, 0, 1);
        disp(1, 3, 1, 2, 0, 0);
        step();
        // R7: slots 1 and 2 granted together jointly wake slot 3
        tag = "R7";
        step();
        tag = "R6";
        step();
        step();

        // R9: stale rows of empty slots 1,2 point at slot 0; reuse slot 0
        tag = "R9";
        disp(0, 0, -1, -1, 1, 1);
        step();
        step();
        step();

        // R2: initial ready-flag combinations
        tag = "R2";
        disp(0, 4, -1, -1, 1, 0);
        disp(1, 5, -1, -1, 0, 1);
        step();
        disp(0, 6, -1, -1, 0, 0);
        disp(1, 8, -1, -1, 1, 1);
        step();
        step();

        // R3: valid slot waiting on a producer that never issues
        tag = "R3";
        disp(0, 7, -1, 6, 1, 0);
        step();
        step();

        // R11: two lanes to one slot, the higher lane wins (not ready)
        tag = "R11";
        disp(0, 9, -1, -1, 1, 1);
        disp(1, 9, -1, -1, 0, 1);
        step();
        step();

        // R4/R5: six consumers of slot 9 wake together, granted two per cycle
        tag = "R4";
        disp(0, 10, 9, -1, 0, 1);
        disp(1, 11, 9, -1, 0, 1);
        step();
        disp(0, 12, 9, -1, 0, 1);
        disp(1, 13, 9, -1, 0, 1);
        step();
        disp(0, 14, 9, -1, 0, 1);
        disp(1, 15, 9, -1, 0, 1);
        step();
        disp(0, 9, -1, -1, 1, 1);
        step();
        step();
        tag = "R5";
        repeat (4) step();

        // R10: flush with a requesting slot and a dispatch in the same cycle
        tag = "R10";
        disp(0, 1, -1, -1, 1, 1);
        step();
        flush = 1'b1;
        disp(0, 2, -1, -1, 1, 1);
        step();
        step();
        disp(0, 3, -1, -1, 1, 1);
        step();
        step();

        done = 1'b1;
        summary();
        $finish;
    end

endmodule